// File: doc/BRIEF.md
# Pong Game Physics Engine

This block advances the state of a two-player pong game once per video frame. Each frame alternates between a render phase, during which the block is idle and its state registers are stable for the renderer, and a compute phase that begins with a one-cycle `start_i` pulse. A compute phase consists of `TICKS` small time steps. In each step the ball and both paddles move by a fraction of a pixel, so collision handling stays simple and local.

Within one tick the block asks for the court obstacles one per cycle, using an index that it presents on `obs_idx_o`. An external table answers with that obstacle's bounding box in the same cycle. The block then tests its own two paddle boxes in the next two cycles. Every hit found along the way is folded into per-axis bounce flags. The last cycle of the tick commits all updates together: the ball step, any bounce, any score with a re-serve, and the two paddle steps driven by the joystick velocities. When the final tick has been committed, a one-cycle `done_o` pulse marks the return to the render phase.

Positions are unsigned fixed point with 10 integer and 6 fraction bits, so one pixel equals 64 units. Velocities are signed fixed point with 2 integer and 6 fraction bits, in units per tick. Paddle 0 sits at the left side and paddle 1 at the right side.

Top module: `pong_physics`

## Requirements
- R1: While `busy_o` is low, the ball, paddle and score outputs hold their values, and a `start_i` pulse that arrives while `busy_o` is high has no effect.
- R2: A `start_i` pulse seen while idle raises `busy_o` at the next edge. The phase lasts TICKS*(N_OBS+2) cycles. `done_o` is high for exactly one cycle, the cycle right after the final commit, and `busy_o` is low in that cycle.
- R3: In each tick `obs_idx_o` counts 0,1,...,N_OBS+1 over consecutive cycles. Indices below N_OBS select the external box (left, right, top, bottom, same 10.6 format, bounds inclusive). Index N_OBS tests paddle 0 and index N_OBS+1 tests paddle 1. A paddle box spans the paddle's column over PAD_W pixels and PAD_H pixels down from its position.
- R4: At each commit, a paddle velocity becomes its old value plus the 8-bit signed joystick value shifted right arithmetically by 4, saturated to the range -128..127.
- R5: At each commit, a paddle position becomes its old value plus the new velocity, clamped to [Y_LO, Y_HI-PAD_H] pixels. When the clamp acts, the paddle velocity is cleared to zero.
- R6: With no hit and no score, a commit adds the ball velocity to the ball position on each axis. Positions are unsigned 10.6 and velocities are signed 2.6.
- R7: A box is hit when the ball's next point lies inside it. If the ball's current x lies outside the box's x range, the x velocity is negated and x is held for that tick. The same rule applies to y with the y range. Each axis is negated at most once per tick, however many boxes are hit.
- R8: If the next x falls below X_LO pixels, score1 increments. If it exceeds X_HI pixels, score0 increments. In either case the ball returns to the court centre with velocity (SERVE_VX, SERVE_VY).
- R9: After reset the ball is at the centre with the serve velocity, both paddles are centred vertically with zero velocity, the scores are zero, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a compute phase |
| joy0_i | input | JOY_W | Signed joystick velocity, paddle 0 |
| joy1_i | input | JOY_W | Signed joystick velocity, paddle 1 |
| obs_idx_o | output | SLOT_W | Index of the box tested in this cycle |
| obs_left_i | input | POS_W | Left edge of the requested obstacle |
| obs_right_i | input | POS_W | Right edge of the requested obstacle |
| obs_top_i | input | POS_W | Top edge of the requested obstacle |
| obs_bottom_i | input | POS_W | Bottom edge of the requested obstacle |
| ball_x_o | output | POS_W | Ball x position |
| ball_y_o | output | POS_W | Ball y position |
| ball_vx_o | output | VEL_W | Ball x velocity |
| ball_vy_o | output | VEL_W | Ball y velocity |
| pad0_y_o | output | POS_W | Paddle 0 top position |
| pad0_v_o | output | VEL_W | Paddle 0 velocity |
| pad1_y_o | output | POS_W | Paddle 1 top position |
| pad1_v_o | output | VEL_W | Paddle 1 velocity |
| score0_o | output | SCORE_W | Points of player 0 |
| score1_o | output | SCORE_W | Points of player 1 |
| busy_o | output | 1 | Compute phase active |
| done_o | output | 1 | One-cycle end-of-phase pulse |

## Verification
The joystick inputs are swept from full negative to full positive in steps of 17, with the two players driven with opposite signs. This separates the arithmetic shift, its sign handling and velocity saturation. It also shows whether the position clamp clears the velocity at both court limits. Three obstacle layouts are used: walls only, a tall block that the ball meets from the side, and a flat block that the ball meets from above. Together they show which axis flips and that x is held on a side hit. Long runs with walls only produce both wall and paddle bounces as well as scores at either side. A second `start_i` issued in the middle of a phase, and an idle wait after `done_o`, separate proper phase gating from a block that restarts or keeps drifting.

// File: rtl/pong_pkg.sv
package pong_pkg;
  localparam int unsigned FRAC = 6;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_RUN
  } seq_state_e;
endpackage

// File: rtl/pong_tick_seq.sv
module pong_tick_seq
  import pong_pkg::*;
#(
  parameter int unsigned TICKS  = 255,
  parameter int unsigned NSLOT  = 5,
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              commit_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [TICK_W-1:0] tick_q;
  logic              done_q;
  logic              commit_w, last_w;

  assign commit_w = (state_q == SEQ_RUN) && (slot_q == SLOT_W'(NSLOT - 1));
  assign last_w   = commit_w && (tick_q == TICK_W'(TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
      tick_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_w;
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_RUN;
            slot_q  <= '0;
            tick_q  <= '0;
          end
        end
        SEQ_RUN: begin
          if (commit_w) begin
            slot_q <= '0;
            if (last_w) state_q <= SEQ_IDLE;
            else        tick_q  <= tick_q + TICK_W'(1);
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == SEQ_RUN);
  assign slot_o   = slot_q;
  assign commit_o = commit_w;
  assign done_o   = done_q;
endmodule

// File: rtl/pong_paddle.sv
module pong_paddle
  import pong_pkg::*;
#(
  parameter int POS_W     = 16,
  parameter int VEL_W     = 8,
  parameter int JOY_W     = 8,
  parameter int JOY_SHIFT = 4,
  parameter int Y_TOP     = 8,
  parameter int Y_BOT     = 423,
  parameter int Y_INIT    = 215
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [JOY_W-1:0] joy_i,
  output logic [POS_W-1:0] y_o,
  output logic [VEL_W-1:0] v_o
);
  localparam int VMAX = 2 ** (VEL_W - 1) - 1;
  localparam int VMIN = -VMAX - 1;
  localparam int SW   = VEL_W + 2;
  localparam int PW   = POS_W + 2;
  localparam int LO   = Y_TOP << FRAC;
  localparam int HI   = Y_BOT << FRAC;

  logic signed [JOY_W-1:0] joy_sh;
  logic signed [VEL_W-1:0] v_q, v_nxt, v_fin;
  logic        [POS_W-1:0] y_q, y_nxt;
  logic signed [SW-1:0]    v_sum;
  logic signed [PW-1:0]    y_sum;

  assign joy_sh = $signed(joy_i) >>> JOY_SHIFT;

  always_comb begin
    v_sum = SW'(v_q) + SW'(joy_sh);
    if (v_sum > SW'(VMAX))      v_nxt = VEL_W'(VMAX);
    else if (v_sum < SW'(VMIN)) v_nxt = VEL_W'(VMIN);
    else                        v_nxt = VEL_W'(v_sum);

    y_sum = $signed({2'b00, y_q}) + PW'(v_nxt);
    if (y_sum < PW'(LO)) begin
      y_nxt = POS_W'(LO);
      v_fin = '0;
    end else if (y_sum > PW'(HI)) begin
      y_nxt = POS_W'(HI);
      v_fin = '0;
    end else begin
      y_nxt = POS_W'(y_sum);
      v_fin = v_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= POS_W'(Y_INIT << FRAC);
      v_q <= '0;
    end else if (commit_i) begin
      y_q <= y_nxt;
      v_q <= v_fin;
    end
  end

  assign y_o = y_q;
  assign v_o = v_q;
endmodule

// File: rtl/pong_ball.sv
module pong_ball
  import pong_pkg::*;
#(
  parameter int POS_W    = 16,
  parameter int VEL_W    = 8,
  parameter int X_LO     = 8,
  parameter int X_HI     = 631,
  parameter int X_C      = 319,
  parameter int Y_C      = 239,
  parameter int SERVE_VX = 96,
  parameter int SERVE_VY = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_en_i,
  input  logic             commit_i,
  input  logic [POS_W-1:0] box_l_i,
  input  logic [POS_W-1:0] box_r_i,
  input  logic [POS_W-1:0] box_t_i,
  input  logic [POS_W-1:0] box_b_i,
  output logic [POS_W-1:0] x_o,
  output logic [POS_W-1:0] y_o,
  output logic [VEL_W-1:0] vx_o,
  output logic [VEL_W-1:0] vy_o,
  output logic [1:0]       point_o
);
  localparam int PW = POS_W + 2;

  logic        [POS_W-1:0] x_q, y_q;
  logic signed [VEL_W-1:0] vx_q, vy_q;
  logic                    fx_q, fy_q;
  logic signed [PW-1:0]    nx, ny;
  logic                    in_box, out_x, out_y, fx_now, fy_now;
  logic                    left_out, right_out;

  always_comb begin
    nx     = $signed({2'b00, x_q}) + PW'(vx_q);
    ny     = $signed({2'b00, y_q}) + PW'(vy_q);
    in_box = (nx >= $signed({2'b00, box_l_i})) && (nx <= $signed({2'b00, box_r_i})) &&
             (ny >= $signed({2'b00, box_t_i})) && (ny <= $signed({2'b00, box_b_i}));
    out_x  = (x_q < box_l_i) || (x_q > box_r_i);
    out_y  = (y_q < box_t_i) || (y_q > box_b_i);
    // hits accumulate per axis; a second hit on the same axis is absorbed
    fx_now = fx_q | (slot_en_i & in_box & out_x);
    fy_now = fy_q | (slot_en_i & in_box & out_y);
    left_out  = !fx_now && (nx < PW'(X_LO << FRAC));
    right_out = !fx_now && (nx > PW'(X_HI << FRAC));
  end

  assign point_o = {commit_i & left_out, commit_i & right_out};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= POS_W'(X_C << FRAC);
      y_q  <= POS_W'(Y_C << FRAC);
      vx_q <= VEL_W'(SERVE_VX);
      vy_q <= VEL_W'(SERVE_VY);
      fx_q <= 1'b0;
      fy_q <= 1'b0;
    end else if (commit_i) begin
      fx_q <= 1'b0;
      fy_q <= 1'b0;
      if (left_out || right_out) begin
        x_q  <= POS_W'(X_C << FRAC);
        y_q  <= POS_W'(Y_C << FRAC);
        vx_q <= VEL_W'(SERVE_VX);
        vy_q <= VEL_W'(SERVE_VY);
      end else begin
        if (fx_now) vx_q <= -vx_q;
        else        x_q  <= POS_W'(nx);
        if (fy_now) vy_q <= -vy_q;
        else        y_q  <= POS_W'(ny);
      end
    end else if (slot_en_i) begin
      fx_q <= fx_now;
      fy_q <= fy_now;
    end
  end

  assign x_o  = x_q;
  assign y_o  = y_q;
  assign vx_o = vx_q;
  assign vy_o = vy_q;
endmodule

// File: rtl/pong_physics.sv
module pong_physics
  import pong_pkg::*;
#(
  parameter int POS_W     = 16,
  parameter int VEL_W     = 8,
  parameter int JOY_W     = 8,
  parameter int JOY_SHIFT = 4,
  parameter int SCORE_W   = 8,
  parameter int TICKS     = 255,
  parameter int N_OBS     = 3,
  parameter int X_LO      = 8,
  parameter int X_HI      = 631,
  parameter int Y_LO      = 8,
  parameter int Y_HI      = 471,
  parameter int PAD_W     = 8,
  parameter int PAD_H     = 48,
  parameter int PAD0_X    = 16,
  parameter int PAD1_X    = 616,
  parameter int SERVE_VX  = 96,
  parameter int SERVE_VY  = 40,
  localparam int NSLOT    = N_OBS + 2,
  localparam int SLOT_W   = $clog2(NSLOT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [JOY_W-1:0]   joy0_i,
  input  logic [JOY_W-1:0]   joy1_i,
  output logic [SLOT_W-1:0]  obs_idx_o,
  input  logic [POS_W-1:0]   obs_left_i,
  input  logic [POS_W-1:0]   obs_right_i,
  input  logic [POS_W-1:0]   obs_top_i,
  input  logic [POS_W-1:0]   obs_bottom_i,
  output logic [POS_W-1:0]   ball_x_o,
  output logic [POS_W-1:0]   ball_y_o,
  output logic [VEL_W-1:0]   ball_vx_o,
  output logic [VEL_W-1:0]   ball_vy_o,
  output logic [POS_W-1:0]   pad0_y_o,
  output logic [VEL_W-1:0]   pad0_v_o,
  output logic [POS_W-1:0]   pad1_y_o,
  output logic [VEL_W-1:0]   pad1_v_o,
  output logic [SCORE_W-1:0] score0_o,
  output logic [SCORE_W-1:0] score1_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int TICK_W = $clog2(TICKS + 1);
  localparam int X_C    = (X_LO + X_HI) / 2;
  localparam int Y_C    = (Y_LO + Y_HI) / 2;

  logic              busy_w, commit_w;
  logic [SLOT_W-1:0] slot_w;
  logic [1:0]        point_w;
  logic [JOY_W-1:0]  joy_w   [2];
  logic [POS_W-1:0]  pad_y_w [2];
  logic [VEL_W-1:0]  pad_v_w [2];
  logic [POS_W-1:0]  pad_l_w [2];
  logic [POS_W-1:0]  pad_r_w [2];
  logic [POS_W-1:0]  pad_b_w [2];
  logic [SCORE_W-1:0] score_q [2];
  logic [POS_W-1:0]  box_l, box_r, box_t, box_b;

  assign joy_w[0] = joy0_i;
  assign joy_w[1] = joy1_i;

  pong_tick_seq #(
    .TICKS (TICKS),
    .NSLOT (NSLOT),
    .SLOT_W(SLOT_W),
    .TICK_W(TICK_W)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_w),
    .slot_o  (slot_w),
    .commit_o(commit_w),
    .done_o  (done_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_side
    localparam int PX = (g == 0) ? PAD0_X : PAD1_X;

    pong_paddle #(
      .POS_W    (POS_W),
      .VEL_W    (VEL_W),
      .JOY_W    (JOY_W),
      .JOY_SHIFT(JOY_SHIFT),
      .Y_TOP    (Y_LO),
      .Y_BOT    (Y_HI - PAD_H),
      .Y_INIT   (Y_C - PAD_H / 2)
    ) i_paddle (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .commit_i(commit_w),
      .joy_i   (joy_w[g]),
      .y_o     (pad_y_w[g]),
      .v_o     (pad_v_w[g])
    );

    assign pad_l_w[g] = POS_W'(PX << FRAC);
    assign pad_r_w[g] = POS_W'((PX + PAD_W) << FRAC);
    assign pad_b_w[g] = pad_y_w[g] + POS_W'(PAD_H << FRAC);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         score_q[g] <= '0;
      else if (point_w[g]) score_q[g] <= score_q[g] + SCORE_W'(1);
    end
  end

  // stream: external obstacles first, then paddle 0, then paddle 1
  always_comb begin
    if (slot_w < SLOT_W'(N_OBS)) begin
      box_l = obs_left_i;
      box_r = obs_right_i;
      box_t = obs_top_i;
      box_b = obs_bottom_i;
    end else if (slot_w == SLOT_W'(N_OBS)) begin
      box_l = pad_l_w[0];
      box_r = pad_r_w[0];
      box_t = pad_y_w[0];
      box_b = pad_b_w[0];
    end else begin
      box_l = pad_l_w[1];
      box_r = pad_r_w[1];
      box_t = pad_y_w[1];
      box_b = pad_b_w[1];
    end
  end

  pong_ball #(
    .POS_W   (POS_W),
    .VEL_W   (VEL_W),
    .X_LO    (X_LO),
    .X_HI    (X_HI),
    .X_C     (X_C),
    .Y_C     (Y_C),
    .SERVE_VX(SERVE_VX),
    .SERVE_VY(SERVE_VY)
  ) i_ball (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slot_en_i(busy_w),
    .commit_i (commit_w),
    .box_l_i  (box_l),
    .box_r_i  (box_r),
    .box_t_i  (box_t),
    .box_b_i  (box_b),
    .x_o      (ball_x_o),
    .y_o      (ball_y_o),
    .vx_o     (ball_vx_o),
    .vy_o     (ball_vy_o),
    .point_o  (point_w)
  );

  assign obs_idx_o = slot_w;
  assign pad0_y_o  = pad_y_w[0];
  assign pad0_v_o  = pad_v_w[0];
  assign pad1_y_o  = pad_y_w[1];
  assign pad1_v_o  = pad_v_w[1];
  assign score0_o  = score_q[0];
  assign score1_o  = score_q[1];
  assign busy_o    = busy_w;
endmodule

// File: rtl/pong_physics_chk.sv
module pong_physics_chk
  import pong_pkg::*;
#(
  parameter int POS_W    = 16,
  parameter int VEL_W    = 8,
  parameter int SCORE_W  = 8,
  parameter int X_LO     = 8,
  parameter int X_HI     = 631,
  parameter int Y_LO     = 8,
  parameter int Y_HI     = 471,
  parameter int PAD_H    = 48,
  parameter int SERVE_VX = 96
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               done_o,
  input logic [POS_W-1:0]   ball_x_o,
  input logic [POS_W-1:0]   ball_y_o,
  input logic [VEL_W-1:0]   ball_vx_o,
  input logic [POS_W-1:0]   pad0_y_o,
  input logic [POS_W-1:0]   pad1_y_o,
  input logic [SCORE_W-1:0] score0_o,
  input logic [SCORE_W-1:0] score1_o
);
  localparam logic [POS_W-1:0] PY_LO = POS_W'(Y_LO << FRAC);
  localparam logic [POS_W-1:0] PY_HI = POS_W'((Y_HI - PAD_H) << FRAC);
  localparam logic [POS_W-1:0] BX_LO = POS_W'(X_LO << FRAC);
  localparam logic [POS_W-1:0] BX_HI = POS_W'(X_HI << FRAC);

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(ball_x_o) && $stable(ball_y_o) && $stable(pad0_y_o) &&
                 $stable(pad1_y_o) && $stable(score0_o) && $stable(score1_o)));

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_pad_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad0_y_o >= PY_LO) && (pad0_y_o <= PY_HI) && (pad1_y_o >= PY_LO) && (pad1_y_o <= PY_HI));

  p_vx_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ball_vx_o != $past(ball_vx_o)) |->
      (($signed(ball_vx_o) == -$signed($past(ball_vx_o))) || (ball_vx_o == VEL_W'(SERVE_VX))));

  p_ball_x_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ball_x_o >= BX_LO) && (ball_x_o <= BX_HI));

  p_score0_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score0_o != $past(score0_o)) |-> (score0_o == $past(score0_o) + SCORE_W'(1)));

  p_score1_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score1_o != $past(score1_o)) |-> (score1_o == $past(score1_o) + SCORE_W'(1)));
endmodule

bind pong_physics pong_physics_chk #(
  .POS_W   (POS_W),
  .VEL_W   (VEL_W),
  .SCORE_W (SCORE_W),
  .X_LO    (X_LO),
  .X_HI    (X_HI),
  .Y_LO    (Y_LO),
  .Y_HI    (Y_HI),
  .PAD_H   (PAD_H),
  .SERVE_VX(SERVE_VX)
) i_pong_physics_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .ball_x_o (ball_x_o),
  .ball_y_o (ball_y_o),
  .ball_vx_o(ball_vx_o),
  .pad0_y_o (pad0_y_o),
  .pad1_y_o (pad1_y_o),
  .score0_o (score0_o),
  .score1_o (score1_o)
);

// File: tb/test_pong_physics.sv
module test_pong_physics;
  localparam int TICKS = 255;
  localparam int N_OBS = 3;
  localparam int NSLOT = N_OBS + 2;
  localparam int FR    = 64;
  localparam int X_LO = 8, X_HI = 631, Y_LO = 8, Y_HI = 471;
  localparam int PAD_W = 8, PAD_H = 48, PAD0_X = 16, PAD1_X = 616;
  localparam int SVX = 96, SVY = 40;
  localparam int XC = (X_LO + X_HI) / 2, YC = (Y_LO + Y_HI) / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  joy0 = '0, joy1 = '0;
  logic [2:0]  idx;
  logic [15:0] obs_l, obs_r, obs_t, obs_b;
  logic [15:0] bx_o, by_o, p0y_o, p1y_o;
  logic [7:0]  bvx_o, bvy_o, p0v_o, p1v_o, s0_o, s1_o;
  logic        busy, done;

  int ol[N_OBS], orr[N_OBS], ot[N_OBS], obt[N_OBS];
  int m_bx, m_by, m_vx, m_vy, m_py[2], m_pv[2], m_s0, m_s1;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  always_comb begin
    if (idx < 3'(N_OBS)) begin
      obs_l = 16'(ol[idx]); obs_r = 16'(orr[idx]);
      obs_t = 16'(ot[idx]); obs_b = 16'(obt[idx]);
    end else begin
      obs_l = '0; obs_r = '0; obs_t = '0; obs_b = '0;
    end
  end

  pong_physics #(
    .TICKS(TICKS), .N_OBS(N_OBS), .X_LO(X_LO), .X_HI(X_HI), .Y_LO(Y_LO), .Y_HI(Y_HI),
    .PAD_W(PAD_W), .PAD_H(PAD_H), .PAD0_X(PAD0_X), .PAD1_X(PAD1_X),
    .SERVE_VX(SVX), .SERVE_VY(SVY)
  ) i_pong_physics (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .joy0_i(joy0), .joy1_i(joy1),
    .obs_idx_o(idx), .obs_left_i(obs_l), .obs_right_i(obs_r), .obs_top_i(obs_t),
    .obs_bottom_i(obs_b), .ball_x_o(bx_o), .ball_y_o(by_o), .ball_vx_o(bvx_o),
    .ball_vy_o(bvy_o), .pad0_y_o(p0y_o), .pad0_v_o(p0v_o), .pad1_y_o(p1y_o),
    .pad1_v_o(p1v_o), .score0_o(s0_o), .score1_o(s1_o), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    check(int'(bx_o) == m_bx, {tag, " R6"}, "ball_x", int'(bx_o), m_bx);
    check(int'(by_o) == m_by, {tag, " R6"}, "ball_y", int'(by_o), m_by);
    check(int'($signed(bvx_o)) == m_vx, {tag, " R7"}, "ball_vx", int'($signed(bvx_o)), m_vx);
    check(int'($signed(bvy_o)) == m_vy, {tag, " R7"}, "ball_vy", int'($signed(bvy_o)), m_vy);
    check(int'(p0y_o) == m_py[0], {tag, " R5"}, "pad0_y", int'(p0y_o), m_py[0]);
    check(int'(p1y_o) == m_py[1], {tag, " R5"}, "pad1_y", int'(p1y_o), m_py[1]);
    check(int'($signed(p0v_o)) == m_pv[0], {tag, " R4"}, "pad0_v", int'($signed(p0v_o)), m_pv[0]);
    check(int'($signed(p1v_o)) == m_pv[1], {tag, " R4"}, "pad1_v", int'($signed(p1v_o)), m_pv[1]);
    check(int'(s0_o) == m_s0, {tag, " R8"}, "score0", int'(s0_o), m_s0);
    check(int'(s1_o) == m_s1, {tag, " R8"}, "score1", int'(s1_o), m_s1);
  endtask

  task automatic model_serve();
    m_bx = XC * FR; m_by = YC * FR; m_vx = SVX; m_vy = SVY;
  endtask

  task automatic model_reset();
    model_serve();
    for (int i = 0; i < 2; i++) begin m_py[i] = (YC - PAD_H / 2) * FR; m_pv[i] = 0; end
    m_s0 = 0; m_s1 = 0;
  endtask

  task automatic model_tick(input int j0, input int j1);
    int nx, ny, l, r, t, b, v, y, j;
    bit fx, fy;
    fx = 0; fy = 0;
    nx = m_bx + m_vx; ny = m_by + m_vy;
    for (int k = 0; k < NSLOT; k++) begin
      if (k < N_OBS) begin l = ol[k]; r = orr[k]; t = ot[k]; b = obt[k]; end
      else begin
        l = ((k == N_OBS) ? PAD0_X : PAD1_X) * FR;
        r = l + PAD_W * FR;
        t = m_py[k - N_OBS];
        b = t + PAD_H * FR;
      end
      if (nx >= l && nx <= r && ny >= t && ny <= b) begin
        if (m_bx < l || m_bx > r) fx = 1;
        if (m_by < t || m_by > b) fy = 1;
      end
    end
    if (!fx && nx < X_LO * FR) begin m_s1++; model_serve(); end
    else if (!fx && nx > X_HI * FR) begin m_s0++; model_serve(); end
    else begin
      if (fx) m_vx = -m_vx; else m_bx = nx;
      if (fy) m_vy = -m_vy; else m_by = ny;
    end
    for (int i = 0; i < 2; i++) begin
      j = (i == 0) ? j0 : j1;
      v = m_pv[i] + (j >>> 4);
      if (v > 127) v = 127;
      if (v < -128) v = -128;
      y = m_py[i] + v;
      if (y < Y_LO * FR) begin m_py[i] = Y_LO * FR; m_pv[i] = 0; end
      else if (y > (Y_HI - PAD_H) * FR) begin m_py[i] = (Y_HI - PAD_H) * FR; m_pv[i] = 0; end
      else begin m_py[i] = y; m_pv[i] = v; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic set_block(input int l, input int r, input int t, input int b);
    ol[2] = l * FR; orr[2] = r * FR; ot[2] = t * FR; obt[2] = b * FR;
  endtask

  task automatic run_frame(input int j0, input int j1, input bit probe, input string tag);
    int n;
    joy0 = 8'(j0); joy1 = 8'(j1);
    @(negedge clk);
    start = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (probe && n == 1) check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
      if (probe && n <= NSLOT + 1)
        check(int'(idx) == (n - 1) % NSLOT, "R3", "obs_idx order", int'(idx), (n - 1) % NSLOT);
      if (probe && n == 100) start = 1'b1; // mid-phase start must be ignored
    end while (!done && n < 5000);
    for (int t = 0; t < TICKS; t++) model_tick(j0, j1);
    check(n == TICKS * NSLOT + 1, "R2", "phase length", n, TICKS * NSLOT + 1);
    check(busy == 1'b0, "R2", "busy in done cycle", int'(busy), 0);
    cmp_all(tag);
    @(negedge clk);
    check(done == 1'b0, "R2", "done width", int'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    ol[0] = 0; orr[0] = 1023 * FR; ot[0] = 0;         obt[0] = Y_LO * FR;
    ol[1] = 0; orr[1] = 1023 * FR; ot[1] = Y_HI * FR; obt[1] = 1023 * FR;
    set_block(1000, 1010, 1000, 1010);
    do_reset();
    cmp_all("R9 reset");
    check(busy == 1'b0, "R9", "busy at reset", int'(busy), 0);
    check(done == 1'b0, "R9", "done at reset", int'(done), 0);

    // first frame carries the R1/R2/R3 probes
    run_frame(0, 0, 1'b1, "R1 frame");
    repeat (20) @(negedge clk);
    cmp_all("R1 idle hold");

    // side entry into a tall block: vx flips, x held
    do_reset();
    set_block(400, 460, 0, 1023);
    run_frame(0, 0, 1'b0, "R7 side");
    check(int'($signed(bvx_o)) == -SVX, "R7", "vx after side hit", int'($signed(bvx_o)), -SVX);

    // entry from above into a flat block
    do_reset();
    set_block(0, 1023, 300, 310);
    run_frame(0, 0, 1'b0, "R7 top");
    run_frame(30, -30, 1'b0, "R7 top2");

    // joystick sweep with walls only
    do_reset();
    set_block(1000, 1010, 1000, 1010);
    for (int j = -128; j <= 127; j += 17) run_frame(j, -j - 1, 1'b0, "R4 sweep");
    run_frame(127, -128, 1'b0, "R5 extremes");
    run_frame(-128, 127, 1'b0, "R5 extremes");
    for (int k = 0; k < 6; k++) run_frame(0, 0, 1'b0, "R6 coast");
    check((m_s0 + m_s1) > 0, "R8", "points scored", m_s0 + m_s1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule